// File: doc/BRIEF.md
# Dual-Issue Pipe Reservation Arbiter

Each clock cycle this block takes up to two instructions, the older in slot 0 and the younger in slot 1, and decides which of them may issue and on which of two ALU pipes. Each candidate comes with a three-bit class code. The block does not decode instructions or check operands. It only resolves structural hazards, meaning the two pipes, a single load/store port and a single branch port.

Some classes hold resources for more than one cycle: the two-part load/store, the two-part multiply and the three-part multiply. The block records these future claims in a short reservation table. The table moves forward by one entry each cycle. A candidate is granted only if its whole footprint, across its issue cycle and the cycles after it, is free of earlier claims and of claims from the older slot in the same cycle. The upstream issue logic holds any instruction that is not granted and offers it again in the next cycle.

Top module: `dip_issue_arbiter`

## Requirements
- R1: Class codes 0 and 7 (plain), 1 (branch) and 2 (one-part load/store) are flexible. A flexible candidate goes to pipe 0 when pipe 0 is free in its issue cycle, otherwise to pipe 1, and it is held when neither pipe is free. The pipe index is 0 or 1.
- R2: At most one candidate of class 2 or 3 (load/store) is granted per cycle, and a load/store port reserved by an earlier issue blocks every load/store.
- R3: At most one branch (class 1) is granted per cycle.
- R4: Class 4 (one-part multiply) issues only on pipe 0 and is held while pipe 0 is busy.
- R5: Class 3 (two-part load/store) occupies both pipes and the load/store port in its issue cycle, then pipe 0 and the load/store port in the next cycle.
- R6: Class 5 (two-part multiply) occupies both pipes in its issue cycle and pipe 0 in the next cycle.
- R7: Class 6 (three-part multiply) occupies both pipes in its issue cycle and in the next cycle, then pipe 0 in the third cycle. One more instruction can issue only in that third cycle, on pipe 1.
- R8: Issue is in order. Slot 1 is granted only when slot 0 is valid and granted in the same cycle.
- R9: When both slots are granted in the same cycle, they are on different pipes.
- R10: `stall` is high exactly when a valid slot is not granted.
- R11: While the synchronous reset is high, nothing is granted. Reset clears all reservations, so the first cycle after reset can issue two plain instructions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s0_valid | input | 1 | Slot 0 (older) candidate present |
| s0_class | input | 3 | Slot 0 class code |
| s1_valid | input | 1 | Slot 1 (younger) candidate present |
| s1_class | input | 3 | Slot 1 class code |
| s0_grant | output | 1 | Slot 0 issues this cycle |
| s0_pipe | output | 1 | Pipe chosen for slot 0 |
| s1_grant | output | 1 | Slot 1 issues this cycle |
| s1_pipe | output | 1 | Pipe chosen for slot 1 |
| stall | output | 1 | A valid slot was held back |

## Verification
A reservation bit that is set when it should not be shows up as a lost grant or a pipe-1 steering in the cycle the bit reaches the head of the table. That is one or two cycles after the multi-part issue that wrote it. A missing bit shows up in the same window as a second grant, or a pipe-0 grant, where the footprint of R5, R6 or R7 forbids it. Each multi-part class is therefore followed by probe pairs in every cycle of its footprint, plus one more cycle to show the table has drained. A table that reset failed to clear is exposed by the first dual issue after reset.

// File: rtl/dip_pkg.sv
package dip_pkg;

  localparam int CLS_W  = 3;
  localparam int FP_LEN = 3;

  typedef enum logic [CLS_W-1:0] {
    C_DEF  = 3'd0,
    C_BR   = 3'd1,
    C_LS1  = 3'd2,
    C_LS2  = 3'd3,
    C_MUL1 = 3'd4,
    C_MUL2 = 3'd5,
    C_MUL3 = 3'd6,
    C_DEF7 = 3'd7
  } cls_e;

  typedef struct packed {
    logic br;
    logic ls;
    logic p1;
    logic p0;
  } res_t;

  typedef res_t [FP_LEN-1:0] foot_t;

  function automatic logic is_flex(cls_e c);
    return (c == C_DEF) || (c == C_DEF7) || (c == C_BR) || (c == C_LS1);
  endfunction

  function automatic logic is_ls(cls_e c);
    return (c == C_LS1) || (c == C_LS2);
  endfunction

  // Resources claimed per cycle offset; sel picks the pipe of a flexible class.
  function automatic foot_t class_foot(cls_e c, logic sel);
    foot_t f;
    f = '0;
    case (c)
      C_BR: begin
        f[0].br = 1'b1;
        f[0].p0 = ~sel;
        f[0].p1 = sel;
      end
      C_LS1: begin
        f[0].ls = 1'b1;
        f[0].p0 = ~sel;
        f[0].p1 = sel;
      end
      C_LS2: begin
        f[0].ls = 1'b1; f[0].p0 = 1'b1; f[0].p1 = 1'b1;
        f[1].ls = 1'b1; f[1].p0 = 1'b1;
      end
      C_MUL1: f[0].p0 = 1'b1;
      C_MUL2: begin
        f[0].p0 = 1'b1; f[0].p1 = 1'b1;
        f[1].p0 = 1'b1;
      end
      C_MUL3: begin
        f[0].p0 = 1'b1; f[0].p1 = 1'b1;
        f[1].p0 = 1'b1; f[1].p1 = 1'b1;
        f[2].p0 = 1'b1;
      end
      default: begin
        f[0].p0 = ~sel;
        f[0].p1 = sel;
      end
    endcase
    return f;
  endfunction

  function automatic logic foot_clash(foot_t a, foot_t b);
    return |(a & b);
  endfunction

endpackage

// File: rtl/dip_resv_table.sv
module dip_resv_table
  import dip_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic  clk,
  input  logic  rst,
  input  foot_t claim,
  output foot_t busy
);

  localparam int LAST = DEPTH - 1;

  res_t tbl [DEPTH];
  res_t nxt [DEPTH];

  // Entry k holds claims for k cycles ahead; everything moves down one per clock.
  for (genvar k = 0; k < DEPTH; k++) begin : g_ent
    res_t upper;
    res_t incoming;
    if (k < LAST) begin : g_up
      assign upper = tbl[k+1];
    end else begin : g_top
      assign upper = '0;
    end
    if (k + 1 < FP_LEN) begin : g_in
      assign incoming = claim[k+1];
    end else begin : g_noin
      assign incoming = '0;
    end
    assign nxt[k] = upper | incoming;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) tbl[i] <= '0;
    end else begin
      tbl <= nxt;
    end
  end

  for (genvar k = 0; k < FP_LEN; k++) begin : g_busy
    if (k < DEPTH) begin : g_have
      assign busy[k] = tbl[k];
    end else begin : g_none
      assign busy[k] = '0;
    end
  end

endmodule

// File: rtl/dip_slot_picker.sv
module dip_slot_picker
  import dip_pkg::*;
(
  input  logic             valid,
  input  logic [CLS_W-1:0] cls,
  input  logic             allow,
  input  foot_t            busy,
  output logic             grant,
  output logic             pipe,
  output foot_t            foot
);

  cls_e  c;
  foot_t fa;
  foot_t fb;
  logic  ok_a;
  logic  ok_b;

  assign c    = cls_e'(cls);
  assign fa   = class_foot(c, 1'b0);
  assign fb   = class_foot(c, 1'b1);
  assign ok_a = ~foot_clash(fa, busy);
  assign ok_b = is_flex(c) & ~foot_clash(fb, busy);

  assign grant = valid & allow & (ok_a | ok_b);
  assign pipe  = ~ok_a & ok_b;
  assign foot  = grant ? (ok_a ? fa : fb) : '0;

endmodule

// File: rtl/dip_issue_arbiter.sv
module dip_issue_arbiter
  import dip_pkg::*;
#(
  parameter int DEPTH = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             s0_valid,
  input  logic [CLS_W-1:0] s0_class,
  input  logic             s1_valid,
  input  logic [CLS_W-1:0] s1_class,
  output logic             s0_grant,
  output logic             s0_pipe,
  output logic             s1_grant,
  output logic             s1_pipe,
  output logic             stall
);

  foot_t busy0;
  foot_t busy1;
  foot_t foot0;
  foot_t foot1;
  foot_t claim;

  dip_resv_table #(.DEPTH(DEPTH)) u_tbl (
    .clk   (clk),
    .rst   (rst),
    .claim (claim),
    .busy  (busy0)
  );

  dip_slot_picker u_old (
    .valid (s0_valid),
    .cls   (s0_class),
    .allow (~rst),
    .busy  (busy0),
    .grant (s0_grant),
    .pipe  (s0_pipe),
    .foot  (foot0)
  );

  // The younger slot sees the older slot's claims as already taken.
  assign busy1 = busy0 | foot0;

  dip_slot_picker u_young (
    .valid (s1_valid),
    .cls   (s1_class),
    .allow (s0_grant),
    .busy  (busy1),
    .grant (s1_grant),
    .pipe  (s1_pipe),
    .foot  (foot1)
  );

  assign claim = foot0 | foot1;
  assign stall = (s0_valid & ~s0_grant) | (s1_valid & ~s1_grant);

  // Named events for the checks below
  logic both_ls;
  logic both_br;
  logic m1_issue;
  logic m2_issue;
  logic m3_issue;
  logic pipe0_used;

  assign both_ls    = s0_grant & s1_grant & is_ls(cls_e'(s0_class)) & is_ls(cls_e'(s1_class));
  assign both_br    = s0_grant & s1_grant & (s0_class == C_BR) & (s1_class == C_BR);
  assign m1_issue   = (s0_grant & (s0_class == C_MUL1)) | (s1_grant & (s1_class == C_MUL1));
  assign m2_issue   = s0_grant & (s0_class == C_MUL2);
  assign m3_issue   = s0_grant & (s0_class == C_MUL3);
  assign pipe0_used = (s0_grant & ~s0_pipe) | (s1_grant & ~s1_pipe);

  assert_one_ls_R2: assert property (@(posedge clk) disable iff (rst) !both_ls);
  assert_one_br_R3: assert property (@(posedge clk) disable iff (rst) !both_br);
  assert_mul1_pipe0_R4: assert property (@(posedge clk) disable iff (rst)
    (s0_grant && s0_class == C_MUL1) |-> !s0_pipe);
  assert_mul1_slot1_R4: assert property (@(posedge clk) disable iff (rst)
    (s1_grant && s1_class == C_MUL1) |-> !s1_pipe);
  assert_mul2_tail_R6: assert property (@(posedge clk) disable iff (rst)
    m2_issue |=> !pipe0_used);
  assert_mul3_hold_R7: assert property (@(posedge clk) disable iff (rst)
    m3_issue |=> (!s0_grant && !s1_grant));
  assert_in_order_R8: assert property (@(posedge clk) disable iff (rst)
    s1_grant |-> (s0_grant && s0_valid));
  assert_split_pipes_R9: assert property (@(posedge clk) disable iff (rst)
    (s0_grant && s1_grant) |-> (s0_pipe != s1_pipe));
  assert_no_dual_m1_R4: assert property (@(posedge clk) disable iff (rst)
    m1_issue |-> !(s0_grant && s1_grant && s0_class == C_MUL1 && s1_class == C_MUL1));

endmodule

// File: tb/dip_issue_arbiter_tb.sv
module dip_issue_arbiter_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  localparam logic [2:0] DEF = 3'd0, BR = 3'd1, LS1 = 3'd2, LS2 = 3'd3;
  localparam logic [2:0] M1 = 3'd4, M2 = 3'd5, M3 = 3'd6, DEF7 = 3'd7;

  typedef struct {
    logic  g0;
    logic  p0;
    logic  g1;
    logic  p1;
    logic  st;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       s0_valid = 1'b0;
  logic [2:0] s0_class = '0;
  logic       s1_valid = 1'b0;
  logic [2:0] s1_class = '0;
  logic       s0_grant, s0_pipe, s1_grant, s1_pipe, stall;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  exp_t sb[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dip_issue_arbiter dut_i (
    .clk      (clk),
    .rst      (rst),
    .s0_valid (s0_valid),
    .s0_class (s0_class),
    .s1_valid (s1_valid),
    .s1_class (s1_class),
    .s0_grant (s0_grant),
    .s0_pipe  (s0_pipe),
    .s1_grant (s1_grant),
    .s1_pipe  (s1_pipe),
    .stall    (stall)
  );

  task automatic check(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of stimulus and queues the expected response
  task automatic step(logic r, logic v0, logic [2:0] c0, logic v1, logic [2:0] c1,
                      logic g0, logic p0, logic g1, logic p1, logic st, string tag);
    exp_t e;
    @(negedge clk);
    rst = r; s0_valid = v0; s0_class = c0; s1_valid = v1; s1_class = c1;
    e.g0 = g0; e.p0 = p0; e.g1 = g1; e.p1 = p1; e.st = st; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: samples a quarter period after the driver and compares
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_PERIOD/4);
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, "s0_grant", s0_grant, e.g0);
        if (e.g0) check(e.tag, "s0_pipe", s0_pipe, e.p0);
        check(e.tag, "s1_grant", s1_grant, e.g1);
        if (e.g1) check(e.tag, "s1_pipe", s1_pipe, e.p1);
        check(e.tag, "stall", stall, e.st);
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    // R11: reset holds grants low
    step(1, 1, DEF, 1, DEF, 0, 0, 0, 0, 1, "R11");
    step(1, 1, DEF, 1, DEF, 0, 0, 0, 0, 1, "R11");
    // R1 / R9: plain pairs split across pipes, code 7 also plain
    step(0, 1, DEF,  1, DEF, 1, 0, 1, 1, 0, "R1");
    step(0, 1, DEF7, 1, DEF, 1, 0, 1, 1, 0, "R9");
    step(0, 1, DEF,  1, LS1, 1, 0, 1, 1, 0, "R1");
    step(0, 1, BR,   1, DEF, 1, 0, 1, 1, 0, "R1");
    // R2 / R3: port limits
    step(0, 1, LS1, 1, LS1, 1, 0, 0, 0, 1, "R2");
    step(0, 1, LS1, 1, LS2, 1, 0, 0, 0, 1, "R2");
    step(0, 1, BR,  1, BR,  1, 0, 0, 0, 1, "R3");
    // R4: one-part multiply is pipe-0 only
    step(0, 1, M1,  1, DEF, 1, 0, 1, 1, 0, "R4");
    step(0, 1, DEF, 1, M1,  1, 0, 0, 0, 1, "R4");
    // R6: two-part multiply
    step(0, 1, M2,  1, DEF, 1, 0, 0, 0, 1, "R6");
    step(0, 1, DEF, 1, DEF, 1, 1, 0, 0, 1, "R6");
    step(0, 1, DEF, 1, DEF, 1, 0, 1, 1, 0, "R6");
    step(0, 1, M2,  0, DEF, 1, 0, 0, 0, 0, "R6");
    step(0, 1, M1,  1, DEF, 0, 0, 0, 0, 1, "R4");
    step(0, 1, M1,  1, DEF, 1, 0, 1, 1, 0, "R4");
    // R7: three-part multiply
    step(0, 1, M3,  0, DEF, 1, 0, 0, 0, 0, "R7");
    step(0, 1, DEF, 1, DEF, 0, 0, 0, 0, 1, "R7");
    step(0, 1, DEF, 1, DEF, 1, 1, 0, 0, 1, "R7");
    step(0, 1, DEF, 1, DEF, 1, 0, 1, 1, 0, "R7");
    // R5: two-part load/store
    step(0, 1, DEF, 1, LS2, 1, 0, 0, 0, 1, "R5");
    step(0, 1, LS2, 0, DEF, 1, 0, 0, 0, 0, "R5");
    step(0, 1, LS1, 1, DEF, 0, 0, 0, 0, 1, "R5");
    step(0, 1, LS1, 1, DEF, 1, 0, 1, 1, 0, "R5");
    step(0, 1, LS2, 0, DEF, 1, 0, 0, 0, 0, "R5");
    step(0, 1, DEF, 1, LS1, 1, 1, 0, 0, 1, "R5");
    // R8 / R10: in-order and stall
    step(0, 0, DEF, 1, DEF, 0, 0, 0, 0, 1, "R8");
    step(0, 0, DEF, 0, DEF, 0, 0, 0, 0, 0, "R10");
    step(0, 1, DEF, 0, DEF, 1, 0, 0, 0, 0, "R10");
    // R11: reset clears a pending three-part reservation
    step(0, 1, M3,  0, DEF, 1, 0, 0, 0, 0, "R11");
    step(1, 1, DEF, 1, DEF, 0, 0, 0, 0, 1, "R11");
    step(0, 1, DEF, 1, DEF, 1, 0, 1, 1, 0, "R11");
    step(0, 0, DEF, 0, DEF, 0, 0, 0, 0, 0, "R10");
    @(negedge clk);
    while (sb.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    finish_run();
  end

endmodule